// File: doc/BRIEF.md
# Frozen Two-Byte Position Readout

This block sits between a free-running up/down position counter and a processor with an 8-bit data path. On every rising clock edge it copies the counter value into a 16-bit holding register. The processor reads the held value one byte at a time through a bus, modelled as a data output plus a separate drive-enable signal.

Pulling the output enable low with the byte select low starts a read. The block samples the two control lines on the falling clock edge. Once it sees a read start, it stops updating the holding register, so the upper and lower bytes always come from the same sample. The processor can then read the bytes at any clock phase.

The freeze lifts only after two things happen in order. First, a falling edge must see the lower byte selected with the output enable still low. Second, a later falling edge must see the output enable high. The holding register resumes loading the counter on the rising edge after the release.

Top module: `qpl_readout`

## Requirements
- R1: While no read is frozen, the holding register loads `count_in` on every rising edge of `clk`.
- R2: A falling edge that samples `oe_n` = 0 and `sel` = 0 while unfrozen freezes the holding register from the next rising edge on.
- R3: With `oe_n` = 0, `sel` = 0 puts bits [15:8] of the holding register on `bus_data`, and `sel` = 1 puts bits [7:0] there.
- R4: `bus_en` equals 1 exactly when `oe_n` is 0; while `bus_en` is 0, `bus_data` is all zeros.
- R5: A freeze is released at a falling edge that samples `oe_n` = 1, but only after an earlier falling edge within the same freeze sampled `oe_n` = 0 with `sel` = 1.
- R6: If `oe_n` returns high before the lower byte was sampled, the freeze stays. A later lower-byte sample followed by `oe_n` high then releases it.
- R7: After a release, the holding register keeps its frozen value until the next rising edge, and on that edge it loads `count_in`.
- R8: Selecting the lower byte (`oe_n` = 0, `sel` = 1) while unfrozen does not freeze, and the holding register keeps tracking.
- R9: Once the lower byte has been sampled during a freeze, switching `sel` back to 0 does not cancel that step, and `oe_n` high still releases.
- R10: A low `rst_n` at a clock edge clears the freeze and sets the holding register to zero; after reset the register tracks again.
- R11: While frozen, the holding register and the selected bus byte stay constant whatever `count_in` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; rising edge loads, falling edge samples controls |
| rst_n | input | 1 | Active-low synchronous reset |
| oe_n | input | 1 | Active-low output enable of the read bus |
| sel | input | 1 | Byte select: 0 = upper byte, 1 = lower byte |
| count_in | input | 16 | Current counter value |
| bus_data | output | 8 | Selected byte of the held position, zero when not driven |
| bus_en | output | 1 | High when the bus is being driven |

## Verification
The hardest window to reach is the half clock cycle between the falling edge that releases a freeze and the following rising edge. In that window the hold has lifted but the register must still show the old sample. The bench waits for that exact falling edge, then briefly pulls the output enable low with the upper byte selected. It restores the enable before the next falling edge so the peek does not start a new freeze. A second delicate path is an aborted read, where the enable rises before the lower byte is selected. The bench drives this case and then reads the register with the same short non-freezing peek, which shows that the freeze survived.

// File: rtl/qpl_pkg.sv
package qpl_pkg;

  // Read handshake phase kept between falling edges
  typedef enum logic [1:0] {
    RD_TRACK    = 2'd0,
    RD_HOLD     = 2'd1,
    RD_LOW_SEEN = 2'd2
  } rd_state_e;

  // Classification of one sample of the bus controls
  typedef enum logic [1:0] {
    REQ_IDLE  = 2'd0,
    REQ_UPPER = 2'd1,
    REQ_LOWER = 2'd2
  } req_e;

  function automatic req_e classify_req(input logic oe_n, input logic sel);
    if (oe_n)      return REQ_IDLE;
    else if (sel)  return REQ_LOWER;
    else           return REQ_UPPER;
  endfunction

  function automatic rd_state_e next_rd_state(input rd_state_e cur, input req_e req);
    rd_state_e nxt;
    nxt = cur;
    case (cur)
      RD_TRACK:    if (req == REQ_UPPER) nxt = RD_HOLD;
      RD_HOLD:     if (req == REQ_LOWER) nxt = RD_LOW_SEEN;
      RD_LOW_SEEN: if (req == REQ_IDLE)  nxt = RD_TRACK;
      default:     nxt = RD_TRACK;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/qpl_inhibit_ctrl.sv
module qpl_inhibit_ctrl
  import qpl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic oe_n,
  input  logic sel,
  output logic inhibit,
  output logic low_seen
);

  rd_state_e state_q;
  rd_state_e state_d;
  req_e      req;

  assign req     = classify_req(oe_n, sel);
  assign state_d = next_rd_state(state_q, req);

  // Controls are sampled on the falling edge
  always_ff @(negedge clk) begin
    if (!rst_n) state_q <= RD_TRACK;
    else        state_q <= state_d;
  end

  assign inhibit  = (state_q != RD_TRACK);
  assign low_seen = (state_q == RD_LOW_SEEN);

endmodule

// File: rtl/qpl_pos_latch.sv
module qpl_pos_latch #(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [POS_W-1:0] count_in,
  output logic [POS_W-1:0] pos_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)     pos_q <= '0;
    else if (!hold) pos_q <= count_in;
  end

endmodule

// File: rtl/qpl_bus_drive.sv
module qpl_bus_drive #(
  parameter int BUS_W = 8,
  localparam int POS_W = 2 * BUS_W
) (
  input  logic [POS_W-1:0] pos_q,
  input  logic             oe_n,
  input  logic             sel,
  output logic [BUS_W-1:0] bus_data,
  output logic             bus_en
);

  function automatic logic [BUS_W-1:0] pick_half(input logic [POS_W-1:0] w, input logic lower);
    return lower ? w[BUS_W-1:0] : w[POS_W-1:BUS_W];
  endfunction

  assign bus_en   = ~oe_n;
  assign bus_data = bus_en ? pick_half(pos_q, sel) : '0;

endmodule

// File: rtl/qpl_readout.sv
module qpl_readout #(
  parameter int BUS_W = 8,
  localparam int POS_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oe_n,
  input  logic             sel,
  input  logic [POS_W-1:0] count_in,
  output logic [BUS_W-1:0] bus_data,
  output logic             bus_en
);

  logic             inhibit;
  logic             low_seen;
  logic [POS_W-1:0] pos_q;

  qpl_inhibit_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .oe_n     (oe_n),
    .sel      (sel),
    .inhibit  (inhibit),
    .low_seen (low_seen)
  );

  qpl_pos_latch #(.POS_W(POS_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (inhibit),
    .count_in (count_in),
    .pos_q    (pos_q)
  );

  qpl_bus_drive #(.BUS_W(BUS_W)) u_bus (
    .pos_q    (pos_q),
    .oe_n     (oe_n),
    .sel      (sel),
    .bus_data (bus_data),
    .bus_en   (bus_en)
  );

endmodule

// File: rtl/qpl_readout_checker.sv
module qpl_readout_checker #(
  parameter int POS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             oe_n,
  input logic             sel,
  input logic [POS_W-1:0] count_in,
  input logic [POS_W-1:0] pos_q,
  input logic             inhibit,
  input logic             low_seen
);

  assert_track_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !inhibit |=> (pos_q == $past(count_in)));

  assert_freeze_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> $stable(pos_q));

  assert_read_start_R2: assert property (@(negedge clk) disable iff (!rst_n)
    (!inhibit && !oe_n && !sel) |=> inhibit);

  assert_release_R5: assert property (@(negedge clk) disable iff (!rst_n)
    (low_seen && oe_n) |=> !inhibit);

  assert_abort_keeps_R6: assert property (@(negedge clk) disable iff (!rst_n)
    (inhibit && !low_seen && oe_n) |=> (inhibit && !low_seen));

  assert_lower_no_freeze_R8: assert property (@(negedge clk) disable iff (!rst_n)
    (!inhibit && !oe_n && sel) |=> !inhibit);

  assert_sel_back_R9: assert property (@(negedge clk) disable iff (!rst_n)
    (low_seen && !oe_n && !sel) |=> low_seen);

  assert_reset_clear_R10: assert property (@(posedge clk)
    !rst_n |=> (pos_q == '0));

endmodule

bind qpl_readout qpl_readout_checker #(.POS_W(POS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .oe_n     (oe_n),
  .sel      (sel),
  .count_in (count_in),
  .pos_q    (pos_q),
  .inhibit  (inhibit),
  .low_seen (low_seen)
);

// File: tb/test_qpl_readout.sv
`timescale 1ns/100ps
module test_qpl_readout;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        oe_n = 1'b1;
  logic        sel = 1'b0;
  logic [15:0] count_in = '0;
  logic [7:0]  bus_data;
  logic        bus_en;
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  qpl_readout i_qpl_readout (
    .clk      (clk),
    .rst_n    (rst_n),
    .oe_n     (oe_n),
    .sel      (sel),
    .count_in (count_in),
    .bus_data (bus_data),
    .bus_en   (bus_en)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one cycle: lands 1 ns after a rising edge, well before the falling edge
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Non-freezing look at both bytes; enable is restored before the next falling edge
  task automatic peek(input string req, input logic [15:0] exp);
    oe_n = 1'b0; sel = 1'b0; #0.2;
    check(req, {15'd0, bus_en}, 16'd1);
    check(req, {8'd0, bus_data}, {8'd0, exp[15:8]});
    sel = 1'b1; #0.2;
    check(req, {8'd0, bus_data}, {8'd0, exp[7:0]});
    oe_n = 1'b1; sel = 1'b0; #0.2;
  endtask

  task automatic t_reset();
    oe_n = 1'b0; sel = 1'b0; count_in = 16'hA5C3;
    step();
    check("R10 reset zero", {8'd0, bus_data}, 16'h0000);
    check("R4 enable low oe", {15'd0, bus_en}, 16'd1);
    oe_n = 1'b1; #0.2;
    check("R4 enable high oe", {15'd0, bus_en}, 16'd0);
    check("R4 idle data zero", {8'd0, bus_data}, 16'h0000);
    rst_n = 1'b1;
    step();
    peek("R10 tracks after reset", 16'hA5C3);
  endtask

  task automatic t_track();
    logic [15:0] vals [4] = '{16'h0001, 16'hFFFF, 16'h8000, 16'h7E81};
    foreach (vals[i]) begin
      count_in = vals[i];
      step();
      peek("R1 tracking", vals[i]);
    end
  endtask

  task automatic t_full_read();
    count_in = 16'h1A2B;
    step();
    oe_n = 1'b0; sel = 1'b0; count_in = 16'h3C4D; #0.2;
    check("R3 upper byte", {8'd0, bus_data}, 16'h001A);
    step();
    check("R2 frozen upper", {8'd0, bus_data}, 16'h001A);
    for (int k = 0; k < 3; k++) begin
      count_in = count_in + 16'h0111;
      step();
      check("R11 stable upper", {8'd0, bus_data}, 16'h001A);
    end
    sel = 1'b1; count_in = 16'h5E6F; #0.2;
    check("R3 lower byte", {8'd0, bus_data}, 16'h002B);
    step();
    check("R11 stable lower", {8'd0, bus_data}, 16'h002B);
    oe_n = 1'b1; #0.2;
    check("R4 released bus off", {15'd0, bus_en}, 16'd0);
    @(negedge clk); #0.5;
    oe_n = 1'b0; sel = 1'b0; #0.2;
    check("R7 no load before rising edge", {8'd0, bus_data}, 16'h001A);
    oe_n = 1'b1; #0.2;
    step();
    peek("R7 load after release", 16'h5E6F);
  endtask

  task automatic t_abort();
    count_in = 16'h4455;
    step();
    oe_n = 1'b0; sel = 1'b0;
    step();
    oe_n = 1'b1; count_in = 16'h6677;
    step();
    step();
    peek("R6 freeze kept after abort", 16'h4455);
    oe_n = 1'b0; sel = 1'b1;
    step();
    oe_n = 1'b1; sel = 1'b0;
    step();
    peek("R6 R5 release after lower then high", 16'h6677);
  endtask

  task automatic t_low_only();
    count_in = 16'h0F1E;
    step();
    oe_n = 1'b0; sel = 1'b1; count_in = 16'h2D3C; #0.2;
    check("R8 lower read", {8'd0, bus_data}, 16'h001E);
    step();
    check("R8 lower keeps tracking", {8'd0, bus_data}, 16'h003C);
    count_in = 16'h4B5A;
    step();
    check("R8 lower keeps tracking 2", {8'd0, bus_data}, 16'h005A);
    oe_n = 1'b1; sel = 1'b0;
    step();
    peek("R8 no freeze", 16'h4B5A);
  endtask

  task automatic t_sel_back();
    count_in = 16'h9988;
    step();
    oe_n = 1'b0; sel = 1'b0;
    step();
    sel = 1'b1;
    step();
    sel = 1'b0; count_in = 16'hBEEF;
    step();
    check("R9 still frozen", {8'd0, bus_data}, 16'h0099);
    oe_n = 1'b1;
    step();
    peek("R9 release after sel back", 16'hBEEF);
  endtask

  task automatic t_reset_mid();
    count_in = 16'hB0B1;
    step();
    oe_n = 1'b0; sel = 1'b0;
    step();
    count_in = 16'hC2C3; rst_n = 1'b0;
    step();
    check("R10 reset clears frozen latch", {8'd0, bus_data}, 16'h0000);
    oe_n = 1'b1;
    step();
    rst_n = 1'b1;
    step();
    peek("R10 freeze cleared", 16'hC2C3);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    t_reset();
    t_track();
    t_full_read();
    t_abort();
    t_low_only();
    t_sel_back();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule